// File: doc/BRIEF.md
# Clock Generator Configuration Slave (SMBus block transfer)

This block is a two-wire serial-bus slave. It holds the six 8-bit configuration bytes that steer a clock generator's output gating and frequency selection. The controller writes the bytes with a block write to one fixed address and reads them back with a block read from the paired address. A write carries a command byte and a byte count ahead of the data. The slave acknowledges both and ignores their values. Data then always fills the bytes from byte 0 upward. A read first returns a byte count and then the register contents.

The slave is clocked by a system clock that runs much faster than the bus. SCL and SDA are brought in through two-flop synchronizers. START and STOP are found as SDA edges while SCL is high. SDA is driven open-drain: the block either pulls the line low or releases it. The configuration bytes leave the block as one flat vector, with byte k on bits [8k+7:8k]. That vector feeds the clock-control logic directly.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 0x69, R/W bit in the LSB = 0, write) or 0xD3 (R/W = 1, read) is acknowledged by pulling SDA low during the ninth clock.
- R2: During a write, the slave acknowledges every byte after the address: the command byte, the byte count and each data byte.
- R3: The values of the command byte and the byte-count byte have no effect on which registers are written or on the values they hold.
- R4: Data bytes of a write go to byte 0, byte 1, up to byte 5, in that order. Every new transfer starts again at byte 0.
- R5: A STOP after any complete data byte ends the write. Bytes that were not sent keep their previous values.
- R6: Data bytes sent after byte 5 are acknowledged and change no register.
- R7: A read returns the count value 6 first, then bytes 0 to 5, each MSB first. A read never changes a register.
- R8: After reset the bytes are 0x00, 0x1D, 0xFF, 0xFF, 0x6B, 0x00 (byte 0 to byte 5) and SDA is released.
- R9: An address byte that matches neither address is not acknowledged. Every later byte is also ignored until the next START: it is not acknowledged and writes nothing.
- R10: Read bytes requested after byte 5 come back as 0xFF, because SDA stays released.
- R11: A master NACK ends a read. The slave then leaves SDA released for the remaining clocks of the transfer.
- R12: A data byte is committed only after its eighth bit. A STOP in the middle of a byte leaves every register unchanged.
- R13: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Configuration bytes, byte k on bits [8k+7:8k] |

## Verification
A wrong bit counter or a wrong phase counter shows at the ports within one byte time. The acknowledge arrives on the wrong clock, or it is missing, and the data lands in the neighbouring register. The reference model catches this on the next clock, because it compares the 48-bit configuration vector on every system clock outside the commit window. A corrupted read pointer or shifter shows up as a wrong byte in the read-back that follows each write. A wrongly held SDA drive shows up as an SDA change during SCL high, or as an acknowledge after an address mismatch, within a single bit period.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_st_t;
endpackage

// File: rtl/cfgs_line_sync.sv
// Brings both bus lines into the system clock domain and reports edges.
module cfgs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // SDA moving while SCL stays high marks bus conditions
  assign start_c  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_c   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/cfgs_regbank.sv
// Configuration bytes held in flops, plus the read-side byte selector.
module cfgs_regbank #(
  parameter int              NREG      = 6,
  parameter int              DW        = 8,
  parameter int              IDX_W     = 3,
  parameter logic [NREG*DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0]   COUNT_VAL = 8'd6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [DW-1:0]        wdata,
  input  logic [IDX_W-1:0]     ridx,
  output logic [DW-1:0]        rdata,
  output logic [NREG*DW-1:0]   regs_flat
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= RST_VAL[g*DW +: DW];
      end else if (we && widx == IDX_W'(g)) begin
        regs[g] <= wdata;
      end
    end
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  // slot 0 carries the count, slots 1..NREG the bytes, beyond that all ones
  always_comb begin
    rdata = '1;
    if (ridx == '0) rdata = COUNT_VAL;
    for (int g = 0; g < NREG; g++) begin
      if (ridx == IDX_W'(g + 1)) rdata = regs[g];
    end
  end
endmodule

// File: rtl/cfgs_engine.sv
// Byte-level protocol engine: address match, acknowledge, write commit, read shift.
module cfgs_engine
  import cfgs_pkg::*;
#(
  parameter int         NREG  = 6,
  parameter int         DW    = 8,
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         IDX_W = 3,
  parameter int         PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             sda_lvl,
  input  logic [DW-1:0]    rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             sda_oe,
  output logic             rd_mode,
  output eng_st_t          st
);
  localparam int              BC_W    = $clog2(DW + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(DW);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DW - 1);
  localparam logic [PH_W-1:0] PH_DATA = PH_W'(3);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(NREG + 3);
  localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(NREG + 1);
  localparam logic [DW-1:0]   WR_ADDR = DW'({ADDR7, 1'b0});
  localparam logic [DW-1:0]   RD_ADDR = DW'({ADDR7, 1'b1});

  logic [BC_W-1:0] bcnt;
  logic [DW-1:0]   sh;
  logic [PH_W-1:0] phase;
  logic            more;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      sh      <= '0;
      phase   <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
      more    <= 1'b0;
      rd_idx  <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st      <= ST_RX;
        bcnt    <= '0;
        phase   <= '0;
        rd_mode <= 1'b0;
        rd_idx  <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && bcnt != BC_FULL) begin
              sh   <= {sh[DW-2:0], sda_lvl};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == BC_FULL) begin
              if (phase == '0) begin
                if (sh == WR_ADDR || sh == RD_ADDR) begin
                  rd_mode <= sh[0];
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (phase >= PH_DATA && phase < PH_END) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IDX_W'(phase - PH_DATA);
                  wr_data <= sh;
                end
              end
              if (phase != PH_END) phase <= phase + 1'b1;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (rd_mode) begin
                st     <= ST_TX;
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[DW-1];
                if (rd_idx != RD_LAST) rd_idx <= rd_idx + 1'b1;
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == BC_LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
                bcnt   <= bcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              more <= ~sda_lvl;
            end else if (scl_fall) begin
              if (more) begin
                st     <= ST_TX;
                bcnt   <= '0;
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[DW-1];
                if (rd_idx != RD_LAST) rd_idx <= rd_idx + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
  import cfgs_pkg::*;
#(
  parameter int                 NREG        = 6,
  parameter int                 DW          = 8,
  parameter logic [6:0]         ADDR7       = 7'h69,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NREG*DW-1:0] RST_VAL     = 48'h00_6B_FF_FF_1D_00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NREG + 2);
  localparam int PH_W  = $clog2(NREG + 4);

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic [DW-1:0]    rd_byte;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DW-1:0]    wr_data;
  logic             rd_mode;
  eng_st_t          st_w;

  cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  cfgs_engine #(
    .NREG(NREG), .DW(DW), .ADDR7(ADDR7), .IDX_W(IDX_W), .PH_W(PH_W)
  ) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_lvl(sda_lvl),
    .rd_byte(rd_byte), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe), .rd_mode(rd_mode), .st(st_w)
  );

  cfgs_regbank #(
    .NREG(NREG), .DW(DW), .IDX_W(IDX_W), .RST_VAL(RST_VAL),
    .COUNT_VAL(DW'(NREG))
  ) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(rd_byte), .regs_flat(cfg_o)
  );
endmodule

// File: rtl/clkcfg_smb_checker.sv
module clkcfg_smb_checker
  import cfgs_pkg::*;
#(
  parameter int                 NREG    = 6,
  parameter int                 DW      = 8,
  parameter logic [NREG*DW-1:0] RST_VAL = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_lvl,
  input logic               scl_fall,
  input logic               sda_oe,
  input logic               rd_mode,
  input eng_st_t            st,
  input logic [NREG*DW-1:0] cfg_o
);
  // R13: the drive only turns on while SCL is low
  p_drive_scl_low_r13: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R8: defaults present and line released right after reset
  p_reset_defaults_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == RST_VAL && !sda_oe));

  // R12: a register only changes two cycles after an SCL fall
  p_commit_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(scl_fall, 2));

  // R7: a read transfer never alters a register
  p_no_write_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> !$past(rd_mode));

  // R9 / R11: when not engaged in a transfer the line is released
  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

bind clkcfg_smb_slave clkcfg_smb_checker #(
  .NREG(NREG), .DW(DW), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
  .sda_oe(sda_oe), .rd_mode(rd_mode), .st(st_w), .cfg_o(cfg_o)
);

// File: tb/clkcfg_smb_slave_tb.sv
module clkcfg_smb_slave_tb;
  localparam int Q = 10;
  localparam logic [47:0] DEF = 48'h00_6B_FF_FF_1D_00;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg;
  logic        sda_line;
  assign sda_line = m_sda & ~sda_oe;

  int   checks = 0;
  int   errors = 0;
  bit   in_ack = 1'b0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  logic [7:0] mdl [6];
  logic [7:0] wbuf [8];

  clkcfg_smb_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] packm();
    logic [47:0] r;
    for (int g = 0; g < 6; g++) r[g*8 +: 8] = mdl[g];
    return r;
  endfunction

  // reference model compared against the outputs on every clock
  always @(negedge clk) begin
    if (mon_en && !rst && !in_ack)
      chk(cfg == packm(), "R4 R12 monitor", cfg, packm());
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq(2*Q);
    m_sda = 1'b0; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) in_ack = 1'b1;
      put_bit(b[i]);
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    acked = ~sda_line; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s1, s2;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q);
      s1 = sda_line; wq(Q-2);
      s2 = sda_line;
      chk(s1 == s2, "R13 sda steady while scl high", s2, s1);
      wq(2);
      m_scl = 1'b0; wq(Q);
      b[i] = s1;
    end
    put_bit(~give_ack);
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] addr, input int n);
    logic a;
    bit   match;
    match = (addr == 8'hD2) || (addr == 8'hD3);
    bus_start();
    send_byte(addr, a);
    chk(a == match, match ? "R1 address ack" : "R9 address nack", a, match);
    in_ack = 1'b0;
    if (match) begin
      send_byte(8'h5A, a); chk(a, "R2 command ack", a, 1); in_ack = 1'b0;
      send_byte(8'h01, a); chk(a, "R3 count ack", a, 1); in_ack = 1'b0;
      for (int k = 0; k < n; k++) begin
        send_byte(wbuf[k], a);
        chk(a, (k < 6) ? "R2 data ack" : "R6 extra byte ack", a, 1);
        wq(1);
        if (k < 6) mdl[k] = wbuf[k];
        in_ack = 1'b0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        send_byte(wbuf[k], a);
        chk(!a, "R9 ignored byte nack", a, 0);
        in_ack = 1'b0;
      end
    end
    bus_stop();
    chk(cfg == packm(), "R3 R4 contents after write", cfg, packm());
  endtask

  task automatic do_read(input int n);
    logic       a;
    logic [7:0] b, e;
    bus_start();
    send_byte(8'hD3, a);
    chk(a, "R1 read address ack", a, 1);
    in_ack = 1'b0;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      if (k == 0) e = 8'd6;
      else if (k <= 6) e = mdl[k-1];
      else e = 8'hFF;
      chk(b == e, (k == 0) ? "R7 count" : ((k <= 6) ? "R7 data" : "R10 past end"),
          b, e);
    end
    bus_stop();
  endtask

  initial begin
    logic       a;
    logic [7:0] b;
    for (int g = 0; g < 6; g++) mdl[g] = DEF[g*8 +: 8];
    wq(6);
    rst = 1'b0;
    wq(1);
    chk(cfg == DEF, "R8 reset contents", cfg, DEF);
    chk(sda_oe == 1'b0, "R8 sda released", sda_oe, 0);
    mon_en = 1'b1;
    wq(4*Q);

    do_read(7);

    wbuf = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h00, 8'h00};
    do_write(8'hD2, 6);
    do_read(7);

    wbuf = '{8'hA1, 8'hB2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    do_write(8'hD2, 2);
    chk(cfg[47:16] == 32'h66554433, "R5 unsent bytes kept", cfg[47:16], 32'h66554433);
    do_read(7);

    wbuf = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7};
    do_write(8'hD2, 8);
    chk(cfg == 48'hC5C4C3C2C1C0, "R6 extra bytes discarded", cfg, 48'hC5C4C3C2C1C0);
    do_read(8);

    wbuf = '{8'hD2, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    do_write(8'hA0, 0);
    do_write(8'hD0, 0);
    chk(cfg == packm(), "R9 mismatch leaves registers", cfg, packm());

    // R11: master NACK on the count, further clocks read released
    bus_start();
    send_byte(8'hD3, a); in_ack = 1'b0;
    chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b0, b);
    chk(b == 8'd6, "R11 count before nack", b, 6);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R11 released after nack", b, 8'hFF);
    bus_stop();

    // R12: STOP after half a data byte commits nothing
    bus_start();
    send_byte(8'hD2, a); in_ack = 1'b0;
    send_byte(8'h00, a); in_ack = 1'b0;
    send_byte(8'h00, a); in_ack = 1'b0;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    wq(Q);
    chk(cfg == packm(), "R12 partial byte dropped", cfg, packm());

    // R4: a fresh transfer starts again at byte 0
    wbuf = '{8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    do_write(8'hD2, 1);
    chk(cfg[7:0] == 8'h3C, "R4 restart at byte 0", cfg[7:0], 8'h3C);
    do_read(7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule